// File: doc/BRIEF.md
# Per-Branch Local-History Direction Predictor

This block guesses whether a conditional branch will be taken by looking at what that same branch did on its own recent executions. A first-level table holds one shift register of past outcomes per branch slot. The slot is chosen by a few low bits of the branch address, just above the instruction alignment bits. The history held in that slot then selects one two-bit saturating counter in a second-level table. The counter's upper bit is the guess.

Fetch logic presents an address on the lookup side and reads a combinational taken/not-taken answer in the same cycle. When the branch resolves, the resolve side supplies the address and the real outcome. In a single clock edge the block then does three things. It uses the branch's history as it stood before the edge to pick a counter. It moves that counter one step toward the outcome. It shifts the outcome into that branch's history. Because each branch keeps its own pattern, successive iterations of a short loop reach different counters, so the exit iteration can be learned.

Top module: `local_hist_predictor`

## Requirements
- R1: After reset every history register holds all zeros and every counter holds weakly taken (2'b10), so every lookup answers taken.
- R2: The history slot is selected by address bits [ALIGN_BITS+HT_IDX_W-1 : ALIGN_BITS]. Addresses that differ only in other bits share one slot.
- R3: The lookup answer is bit 1 of the counter indexed by the current history of the looked-up branch's slot.
- R4: On a resolve, the outcome (taken = 1) enters history bit 0, each older bit moves up one place, and the oldest bit is dropped.
- R5: A counter at 2'b11 stays at 2'b11 on a taken outcome, and a counter at 2'b00 stays at 2'b00 on a not-taken outcome.
- R6: On a resolve, the counter indexed by the branch's pre-update history goes up one on taken and down one on not taken, within the limits of R5.
- R7: A lookup in the same cycle as a resolve sees the state before that resolve. The resolve becomes visible from the next cycle on.
- R8: A branch that repeats a fixed outcome pattern with period at most HIST_W is predicted correctly on every execution once trained, its exit outcome included.
- R9: A resolve changes only the updated branch's history slot and one counter. Without a resolve, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| rs_valid | input | 1 | A resolved branch is presented this cycle |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome of the resolved branch (1 = taken) |

## Verification
The bench checks reset state in every slot, then trains a period-four loop pattern and expects every execution to be called right, the not-taken exit included. A design that indexed counters by address, or by the history after the shift, would miss that exit. Long same-direction runs drive counters to both limits; a design that wrapped instead of saturating would flip its guess after one more outcome. Random traffic includes addresses that alias only in high or alignment bits, and lookups in the same cycle as a resolve of the same branch. These catch a wrong slot slice, disturbance of other slots, and a lookup that sees the new state one cycle early.

// File: rtl/lhp_pkg.sv
package lhp_pkg;
   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } ctr_e;

   function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
      logic [1:0] nxt;
      if (taken) nxt = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
      return nxt;
   endfunction
endpackage

// File: rtl/lhp_hist_table.sv
module lhp_hist_table #(
   parameter int ENTRIES = 16,
   parameter int HIST_W  = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [HIST_W-1:0] rd_hist,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_taken,
   output logic [HIST_W-1:0] wr_old_hist
);
   logic [ENTRIES-1:0][HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_nxt;

   assign rd_hist     = hist_q[rd_idx];
   assign wr_old_hist = hist_q[wr_idx];

   generate
      if (HIST_W == 1) begin : g_one_bit
         assign hist_nxt = wr_taken;
      end else begin : g_shift
         assign hist_nxt = {wr_old_hist[HIST_W-2:0], wr_taken};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (wr_en) begin
         hist_q[wr_idx] <= hist_nxt;
      end
   end

   // R4: the newest outcome lands in bit 0 of the written slot
   a_r4_newest_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> hist_q[$past(wr_idx)][0] == $past(wr_taken));
   // R9: no resolve, no history change
   a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(hist_q));
endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
   import lhp_pkg::*;
#(
   parameter int HIST_W = 4,
   localparam int DEPTH = 1 << HIST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HIST_W-1:0] rd_idx,
   output logic              rd_taken,
   input  logic              wr_en,
   input  logic [HIST_W-1:0] wr_idx,
   input  logic              wr_taken
);
   logic [DEPTH-1:0][1:0] ctr_q;
   logic [1:0] wr_old;

   assign wr_old   = ctr_q[wr_idx];
   assign rd_taken = ctr_q[rd_idx][1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctr_q <= {DEPTH{CTR_WEAK_T}};
      end else if (wr_en) begin
         ctr_q[wr_idx] <= ctr_step(wr_old, wr_taken);
      end
   end

   // R5: saturation at the top
   a_r5_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && wr_old == 2'b11) |=> ctr_q[$past(wr_idx)] == 2'b11);
   // R5: saturation at the bottom
   a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && wr_old == 2'b00) |=> ctr_q[$past(wr_idx)] == 2'b00);
   // R6: taken never lowers a counter, not-taken never raises one
   a_r6_direction: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (($past(wr_taken) && ctr_q[$past(wr_idx)] >= $past(wr_old)) ||
                 (!$past(wr_taken) && ctr_q[$past(wr_idx)] <= $past(wr_old))));
   // R9: no resolve, no counter change
   a_r9_ctr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctr_q));
endmodule

// File: rtl/local_hist_predictor.sv
module local_hist_predictor #(
   parameter int PC_W       = 32,
   parameter int ALIGN_BITS = 2,
   parameter int HT_ENTRIES = 16,
   parameter int HIST_W     = 4,
   localparam int HT_IDX_W  = $clog2(HT_ENTRIES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   input  logic            rs_valid,
   input  logic [PC_W-1:0] rs_pc,
   input  logic            rs_taken
);
   localparam logic [PC_W-1:0] IDX_MASK =
      PC_W'(((64'd1 << HT_IDX_W) - 64'd1) << ALIGN_BITS);

   generate
      if (HIST_W < 1 || HIST_W > 12) begin : g_bad_hist
         $error("HIST_W must be between 1 and 12");
      end
      if (HT_ENTRIES < 2 || (1 << HT_IDX_W) != HT_ENTRIES) begin : g_bad_depth
         $error("HT_ENTRIES must be a power of two of at least 2");
      end
      if (ALIGN_BITS < 0 || ALIGN_BITS + HT_IDX_W > PC_W) begin : g_bad_align
         $error("index bits do not fit in the address");
      end
   endgenerate

   logic [HT_IDX_W-1:0] lk_slot, rs_slot;
   logic [HIST_W-1:0]   lk_hist, rs_hist;
   logic                unused_pc_bits;

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign lk_slot = lk_pc[HT_IDX_W-1:0];
         assign rs_slot = rs_pc[HT_IDX_W-1:0];
      end else begin : g_align
         assign lk_slot = lk_pc[ALIGN_BITS +: HT_IDX_W];
         assign rs_slot = rs_pc[ALIGN_BITS +: HT_IDX_W];
      end
   endgenerate

   assign unused_pc_bits = ^((lk_pc | rs_pc) & ~IDX_MASK);

   lhp_hist_table #(.ENTRIES(HT_ENTRIES), .HIST_W(HIST_W)) u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_idx     (lk_slot),
      .rd_hist    (lk_hist),
      .wr_en      (rs_valid),
      .wr_idx     (rs_slot),
      .wr_taken   (rs_taken),
      .wr_old_hist(rs_hist)
   );

   lhp_pattern_table #(.HIST_W(HIST_W)) u_pht (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_hist),
      .rd_taken(lk_taken),
      .wr_en   (rs_valid),
      .wr_idx  (rs_hist),
      .wr_taken(rs_taken)
   );

   // R1: first cycle after reset release answers taken
   a_r1_reset_taken: assert property (@(posedge clk)
      $rose(rst_n) |-> lk_taken);
endmodule

// File: tb/local_hist_predictor_tb.sv
module local_hist_predictor_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PC_W = 32, ALIGN = 2, ENT = 16, HW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [PC_W-1:0] lk_pc = '0, rs_pc = '0;
   logic rs_valid = 1'b0, rs_taken = 1'b0;
   logic lk_taken;

   int checks = 0, errors = 0;
   logic [HW-1:0] m_hist [ENT];
   logic [1:0]    m_ctr  [1<<HW];

   always #(CLK_PERIOD/2) clk = ~clk;

   local_hist_predictor #(.PC_W(PC_W), .ALIGN_BITS(ALIGN), .HT_ENTRIES(ENT), .HIST_W(HW)) u_dut (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

   function automatic int slot_of(input logic [PC_W-1:0] pc);
      return int'((pc >> ALIGN) & (ENT-1));
   endfunction

   function automatic logic model_pred(input logic [PC_W-1:0] pc);
      return m_ctr[m_hist[slot_of(pc)]][1];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < ENT; i++) m_hist[i] = '0;
      for (int i = 0; i < (1<<HW); i++) m_ctr[i] = 2'b10;
   endtask

   task automatic model_update(input logic [PC_W-1:0] pc, input logic t);
      int s;
      logic [HW-1:0] h;
      s = slot_of(pc);
      h = m_hist[s];
      if (t && m_ctr[h] != 2'b11) m_ctr[h] = m_ctr[h] + 2'd1;
      else if (!t && m_ctr[h] != 2'b00) m_ctr[h] = m_ctr[h] - 2'd1;
      m_hist[s] = {h[HW-2:0], t};
   endtask

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic step(input logic [PC_W-1:0] lpc, input logic v,
                       input logic [PC_W-1:0] rpc, input logic t, input string tag);
      @(negedge clk);
      lk_pc = lpc; rs_valid = v; rs_pc = rpc; rs_taken = t;
      #1;
      check(tag, lk_taken, model_pred(lpc));
      @(posedge clk);
      if (v) model_update(rpc, t);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rs_valid = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      model_reset();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [PC_W-1:0] loop_pc;
      logic pat [4];
      void'($urandom(32'h5EED_1234));
      do_reset();

      // R1: every slot answers taken after reset
      for (int i = 0; i < ENT; i++) begin
         @(negedge clk); lk_pc = PC_W'(i << ALIGN); #1;
         check("R1 reset taken", lk_taken, 1'b1);
      end

      // R5: drive slot 3 to strongly not taken, then many more not-taken
      for (int i = 0; i < 8; i++) step(32'h0C, 1'b1, 32'h0C, 1'b0, "R5 low run");
      @(negedge clk); rs_valid = 1'b0; lk_pc = 32'h0C; #1;
      check("R5 saturated low predicts not taken", lk_taken, 1'b0);
      // one taken leaves history 0001, counter 1 still weak taken
      step(32'h0C, 1'b1, 32'h0C, 1'b1, "R6 single taken");
      // R5: drive slot 5 history to 1111 and saturate counter 15 high
      for (int i = 0; i < 10; i++) step(32'h14, 1'b1, 32'h14, 1'b1, "R5 high run");
      // R6: one not taken from 11 to 10 at history 1111 -> history 1110
      step(32'h14, 1'b1, 32'h14, 1'b0, "R6 step down");

      // R2: aliases in high bits and alignment bits
      step(32'h0000_1014, 1'b0, 32'h0, 1'b0, "R2 high-bit alias");
      step(32'h0000_0017, 1'b0, 32'h0, 1'b0, "R2 align-bit alias");
      @(negedge clk); lk_pc = 32'hFFFF_FF0F; #1;
      check("R2 alias slot 3 value", lk_taken, model_pred(32'h0C));

      // R7: same-cycle lookup sees pre-update state
      do_reset();
      step(32'h20, 1'b1, 32'h20, 1'b0, "R7 same cycle pre-update");
      step(32'h20, 1'b1, 32'h20, 1'b0, "R7 next cycle");
      @(negedge clk); rs_valid = 1'b0; lk_pc = 32'h20; #1;
      check("R7 update visible", lk_taken, 1'b0);

      // R9: idle cycles change nothing
      for (int i = 0; i < 4; i++) step(32'h20, 1'b0, 32'h20, 1'b1, "R9 idle hold");

      // R8: trip-count-4 loop pattern T T T N
      do_reset();
      loop_pc = 32'h0000_0444;
      pat[0] = 1'b1; pat[1] = 1'b1; pat[2] = 1'b1; pat[3] = 1'b0;
      for (int i = 0; i < 48; i++) begin
         @(negedge clk);
         lk_pc = loop_pc; rs_valid = 1'b1; rs_pc = loop_pc; rs_taken = pat[i%4];
         #1;
         if (i >= 32) check("R8 loop outcome", lk_taken, pat[i%4]);
         @(posedge clk);
         model_update(loop_pc, pat[i%4]);
      end

      // R3 R4 R6 R9: random traffic against the model
      do_reset();
      for (int i = 0; i < 3000; i++) begin
         logic [PC_W-1:0] a, b;
         a = $urandom; b = $urandom;
         if (($urandom % 4) == 0) a = b;
         step(a, ($urandom % 4) != 0, b, ($urandom % 3) != 0, "R3 R4 R6 R9 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule